// File: doc/BRIEF.md
# Window-Based Lock Detector with Holdover Control

This block decides whether a reference-tracking loop is locked, and it controls when the loop enters and leaves holdover. The reference and feedback edges arrive as single-cycle strobes in the fast system-clock domain. The block pairs each reference edge with a feedback edge and measures, in system-clock ticks, how far apart the two edges are. Each completed pairing is one phase-detector cycle.

A pairing whose error is below a programmable window advances a run counter. A pairing at or beyond the window, or an edge that never finds a partner, clears the counter. A three-state controller (acquire, locked, holdover) watches this count against two thresholds. The first threshold declares lock. The second is the number of consecutive in-window cycles that releases the loop from holdover.

A clock-switch event forces holdover when holdover is enabled. The holdover-active output lets a downstream DAC controller freeze or override its tuning value.

Top module: `lk_lock_holdover`

## Requirements
- R1: A phase-detector cycle whose error in ticks is strictly less than `windowSize` increments `runCount` by one.
- R2: In acquire, an in-window cycle that brings `runCount` to `lockThresh` or above moves the block to locked. `lockDetect` is high exactly while locked.
- R3: In holdover, the block stays in holdover until an in-window cycle brings `runCount` to `exitThresh` or above. It then returns to acquire and keeps the count. Any miss in holdover clears the count, and the block stays in holdover.
- R4: A `clkSwitch` pulse outside holdover, with `holdEnable` high, enters holdover and clears `runCount`. This takes priority over a result on the same edge. With `holdEnable` low, the pulse has no effect on state or count. In holdover, the pulse is ignored.
- R5: A cycle whose error is equal to or greater than `windowSize` clears `runCount` to 0 and drops lock (locked returns to acquire).
- R6: The error of a cycle is the number of clock edges between its opening edge and its closing edge of the other kind. Edges of both kinds on one edge give an error of 0. Either side may lead. The following cycles count as out of window:
  - a second edge of the opening kind that arrives before any partner (this second edge opens a new pairing);
  - a pending edge with no partner after `TIMEOUT` ticks.
- R7: `runCount` saturates at 2^CNT_W-1 and does not wrap.
- R8: While `rst` is high on a clock edge, the block returns to acquire with all counters and pending edges cleared. The state codes on `loopState` are acquire=0, locked=1, holdover=2.
- R9: A closing edge sampled on clock edge k changes `runCount` and the state on edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refEdge | input | 1 | Reference edge strobe |
| fbEdge | input | 1 | Feedback edge strobe |
| clkSwitch | input | 1 | Clock-switch event pulse |
| holdEnable | input | 1 | Allows holdover entry on a switch event |
| windowSize | input | WIN_W | Phase-error window in ticks |
| lockThresh | input | CNT_W | In-window count needed to declare lock |
| exitThresh | input | CNT_W | In-window count needed to leave holdover |
| lockDetect | output | 1 | High while locked |
| holdActive | output | 1 | High while in holdover |
| loopState | output | 2 | Current state code |
| runCount | output | CNT_W | Consecutive in-window cycle count |

## Verification
The assertions take three things for granted about the inputs:
- the edge strobes are already synchronous to `clk`;
- `clkSwitch` is a plain pulse;
- the thresholds and window hold steady for one clock around each result, since the saturation and lock checks compare against their value on the preceding edge.

The stimulus changes register inputs only between phase-detector cycles. It draws edge offsets, edge order, orphan edges and switch events from a seeded `$urandom`. The windows it draws stay below the timeout, so a legitimately paired edge is never lost to it.

// File: rtl/lk_pkg.sv
package lk_pkg;

  typedef enum logic [1:0] {
    ST_ACQUIRE  = 2'd0,
    ST_LOCKED   = 2'd1,
    ST_HOLDOVER = 2'd2
  } loop_state_e;

  // One strobe per completed phase-detector cycle, from the meter to the control
  typedef struct packed {
    logic pdDone;
    logic inWindow;
  } pd_result_t;

  // Commands from the control to the run counter
  typedef struct packed {
    logic inc;
    logic clr;
  } cnt_cmd_t;

endpackage

// File: rtl/lk_phase_meter.sv
module lk_phase_meter
  import lk_pkg::*;
#(
  parameter int WIN_W   = 8,
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic [WIN_W-1:0] windowSize,
  output pd_result_t       pdRes
);

  localparam int GAP_W = $clog2(TIMEOUT + 1);
  localparam logic [GAP_W-1:0] GAP_LIMIT = GAP_W'(TIMEOUT);

  logic             refPend, fbPend;
  logic             refPendN, fbPendN;
  logic [GAP_W-1:0] gap, gapN;
  logic             doneC, orphanC, inWinC;
  logic [GAP_W-1:0] errC;
  logic             openEdge, closeEdge;

  assign openEdge  = refPend ? refEdge : fbEdge;
  assign closeEdge = refPend ? fbEdge  : refEdge;

  always_comb begin
    refPendN = refPend;
    fbPendN  = fbPend;
    gapN     = gap;
    doneC    = 1'b0;
    orphanC  = 1'b0;
    errC     = '0;
    if (!refPend && !fbPend) begin
      if (refEdge && fbEdge) begin
        doneC = 1'b1;
      end else if (refEdge) begin
        refPendN = 1'b1;
        gapN     = GAP_W'(1);
      end else if (fbEdge) begin
        fbPendN = 1'b1;
        gapN    = GAP_W'(1);
      end
    end else begin
      if (closeEdge) begin
        doneC = 1'b1;
        errC  = gap;
        if (openEdge) begin
          gapN = GAP_W'(1);
        end else begin
          refPendN = 1'b0;
          fbPendN  = 1'b0;
        end
      end else if (openEdge) begin
        doneC   = 1'b1;
        orphanC = 1'b1;
        gapN    = GAP_W'(1);
      end else if (gap >= GAP_LIMIT) begin
        doneC    = 1'b1;
        orphanC  = 1'b1;
        refPendN = 1'b0;
        fbPendN  = 1'b0;
      end else begin
        gapN = gap + GAP_W'(1);
      end
    end
  end

  assign inWinC = !orphanC && (32'(errC) < 32'(windowSize));

  always_ff @(posedge clk) begin
    if (rst) begin
      refPend        <= 1'b0;
      fbPend         <= 1'b0;
      gap            <= '0;
      pdRes.pdDone   <= 1'b0;
      pdRes.inWindow <= 1'b0;
    end else begin
      refPend        <= refPendN;
      fbPend         <= fbPendN;
      gap            <= gapN;
      pdRes.pdDone   <= doneC;
      pdRes.inWindow <= doneC && inWinC;
    end
  end

endmodule

// File: rtl/lk_sat_counter.sv
module lk_sat_counter
  import lk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_cmd_t         cmd,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || cmd.clr) begin
      count <= '0;
    end else if (cmd.inc && count != CNT_MAX) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/lk_mode_ctrl.sv
module lk_mode_ctrl
  import lk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pd_result_t       pdRes,
  input  logic             clkSwitch,
  input  logic             holdEnable,
  input  logic [CNT_W-1:0] lockThresh,
  input  logic [CNT_W-1:0] exitThresh,
  input  logic [CNT_W-1:0] runCount,
  output cnt_cmd_t         cntCmd,
  output loop_state_e      state
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  loop_state_e      stateN;
  logic [CNT_W-1:0] countN;
  logic             enterHold;

  assign countN    = (runCount == CNT_MAX) ? CNT_MAX : runCount + CNT_W'(1);
  assign enterHold = clkSwitch && holdEnable && (state != ST_HOLDOVER);

  always_comb begin
    stateN     = state;
    cntCmd.inc = 1'b0;
    cntCmd.clr = 1'b0;
    if (enterHold) begin
      stateN     = ST_HOLDOVER;
      cntCmd.clr = 1'b1;
    end else if (pdRes.pdDone) begin
      if (pdRes.inWindow) begin
        cntCmd.inc = 1'b1;
        unique case (state)
          ST_ACQUIRE:  if (countN >= lockThresh) stateN = ST_LOCKED;
          ST_HOLDOVER: if (countN >= exitThresh) stateN = ST_ACQUIRE;
          default:     stateN = state;
        endcase
      end else begin
        cntCmd.clr = 1'b1;
        if (state == ST_LOCKED) stateN = ST_ACQUIRE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ACQUIRE;
    else     state <= stateN;
  end

endmodule

// File: rtl/lk_lock_holdover.sv
module lk_lock_holdover
  import lk_pkg::*;
#(
  parameter int WIN_W   = 8,
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic             clkSwitch,
  input  logic             holdEnable,
  input  logic [WIN_W-1:0] windowSize,
  input  logic [CNT_W-1:0] lockThresh,
  input  logic [CNT_W-1:0] exitThresh,
  output logic             lockDetect,
  output logic             holdActive,
  output logic [1:0]       loopState,
  output logic [CNT_W-1:0] runCount
);

  pd_result_t  pdRes;
  cnt_cmd_t    cntCmd;
  loop_state_e state;

  lk_phase_meter #(.WIN_W(WIN_W), .TIMEOUT(TIMEOUT)) uMeter (
    .clk(clk), .rst(rst), .refEdge(refEdge), .fbEdge(fbEdge),
    .windowSize(windowSize), .pdRes(pdRes)
  );

  lk_mode_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst(rst), .pdRes(pdRes), .clkSwitch(clkSwitch),
    .holdEnable(holdEnable), .lockThresh(lockThresh), .exitThresh(exitThresh),
    .runCount(runCount), .cntCmd(cntCmd), .state(state)
  );

  lk_sat_counter #(.CNT_W(CNT_W)) uCount (
    .clk(clk), .rst(rst), .cmd(cntCmd), .count(runCount)
  );

  assign lockDetect = (state == ST_LOCKED);
  assign holdActive = (state == ST_HOLDOVER);
  assign loopState  = state;

endmodule

// File: rtl/lk_lock_holdover_chk.sv
module lk_lock_holdover_chk
  import lk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clkSwitch,
  input logic             holdEnable,
  input logic [CNT_W-1:0] lockThresh,
  input logic [CNT_W-1:0] exitThresh,
  input logic             lockDetect,
  input logic             holdActive,
  input logic [1:0]       loopState,
  input logic [CNT_W-1:0] runCount,
  input pd_result_t       pdRes
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic switchTakes;
  assign switchTakes = clkSwitch && holdEnable && !holdActive;

  p_inc_r1: assert property (@(posedge clk) disable iff (rst)
    pdRes.pdDone && pdRes.inWindow && !switchTakes && runCount != CNT_MAX
    |=> runCount == $past(runCount) + CNT_W'(1));

  p_lock_count_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lockDetect) |-> runCount >= $past(lockThresh));

  p_hold_exit_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(holdActive) |-> runCount >= $past(exitThresh));

  p_switch_enter_r4: assert property (@(posedge clk) disable iff (rst)
    switchTakes |=> holdActive && runCount == '0);

  p_switch_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    clkSwitch && !holdEnable && !pdRes.pdDone |=> $stable(loopState) && $stable(runCount));

  p_miss_clears_r5: assert property (@(posedge clk) disable iff (rst)
    pdRes.pdDone && !pdRes.inWindow |=> runCount == '0 && !lockDetect);

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    runCount == CNT_MAX |=> runCount == CNT_MAX || runCount == '0);

  p_state_legal_r8: assert property (@(posedge clk) disable iff (rst)
    loopState != 2'd3 && !(lockDetect && holdActive));

endmodule

bind lk_lock_holdover lk_lock_holdover_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .clkSwitch(clkSwitch), .holdEnable(holdEnable),
  .lockThresh(lockThresh), .exitThresh(exitThresh), .lockDetect(lockDetect),
  .holdActive(holdActive), .loopState(loopState), .runCount(runCount),
  .pdRes(pdRes)
);

// File: tb/lk_lock_holdover_test.sv
module lk_lock_holdover_test;

  localparam int WIN_W   = 8;
  localparam int CNT_W   = 8;
  localparam int TIMEOUT = 64;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refEdge = 1'b0, fbEdge = 1'b0, clkSwitch = 1'b0, holdEnable = 1'b0;
  logic [WIN_W-1:0] windowSize = 8'd4;
  logic [CNT_W-1:0] lockThresh = 8'd3, exitThresh = 8'd4;
  logic lockDetect, holdActive;
  logic [1:0] loopState;
  logic [CNT_W-1:0] runCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int mState, mCnt, mGap;
  bit mRefP, mFbP, mResV, mResIn;

  always #5 clk = ~clk;

  lk_lock_holdover #(.WIN_W(WIN_W), .CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) uut (
    .clk(clk), .rst(rst), .refEdge(refEdge), .fbEdge(fbEdge),
    .clkSwitch(clkSwitch), .holdEnable(holdEnable), .windowSize(windowSize),
    .lockThresh(lockThresh), .exitThresh(exitThresh), .lockDetect(lockDetect),
    .holdActive(holdActive), .loopState(loopState), .runCount(runCount)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    mState = 0; mCnt = 0; mGap = 0;
    mRefP = 0; mFbP = 0; mResV = 0; mResIn = 0;
  endfunction

  function automatic void modelStep(bit r, bit f, bit s);
    int n, err;
    bit v, orph, op, cl;
    // control (R2 R3 R4 R5 R7), uses the result registered on the previous edge
    if (s && holdEnable && mState != 2) begin
      mState = 2; mCnt = 0;
    end else if (mResV) begin
      if (mResIn) begin
        n = (mCnt == CMAX) ? CMAX : mCnt + 1;
        mCnt = n;
        if (mState == 0 && n >= int'(lockThresh)) mState = 1;
        else if (mState == 2 && n >= int'(exitThresh)) mState = 0;
      end else begin
        mCnt = 0;
        if (mState == 1) mState = 0;
      end
    end
    // meter (R6)
    v = 0; orph = 0; err = 0;
    if (!mRefP && !mFbP) begin
      if (r && f) v = 1;
      else if (r) begin mRefP = 1; mGap = 1; end
      else if (f) begin mFbP = 1; mGap = 1; end
    end else begin
      op = mRefP ? r : f;
      cl = mRefP ? f : r;
      if (cl) begin
        v = 1; err = mGap;
        if (op) mGap = 1;
        else begin mRefP = 0; mFbP = 0; end
      end else if (op) begin
        v = 1; orph = 1; mGap = 1;
      end else if (mGap >= TIMEOUT) begin
        v = 1; orph = 1; mRefP = 0; mFbP = 0;
      end else mGap = mGap + 1;
    end
    mResV  = v;
    mResIn = v && !orph && (err < int'(windowSize));
  endfunction

  // One clock: drive at a negedge, step model, compare at the next negedge
  task automatic tick(bit r, bit f, bit s);
    refEdge = r; fbEdge = f; clkSwitch = s;
    modelStep(r, f, s);
    @(posedge clk);
    @(negedge clk);
    refEdge = 0; fbEdge = 0; clkSwitch = 0;
    chk("R8 state", int'(loopState), mState);
    chk("R2 lockDetect", int'(lockDetect), int'(mState == 1));
    chk("R3 holdActive", int'(holdActive), int'(mState == 2));
    chk("R1 runCount", int'(runCount), mCnt);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  // Pair: opening edge, closing edge 'off' ticks later (0 = same tick), then idles
  task automatic doPair(bit refFirst, int off, int after);
    if (off == 0) tick(1, 1, 0);
    else begin
      tick(refFirst, !refFirst, 0);
      idle(off - 1);
      tick(!refFirst, refFirst, 0);
    end
    idle(after);
  endtask

  task automatic doReset();
    rst = 1; refEdge = 0; fbEdge = 0; clkSwitch = 0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst = 0;
    modelReset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED1234);
    @(negedge clk);
    doReset();
    // R8: reset state
    chk("R8 reset state", int'(loopState), 0);
    chk("R8 reset count", int'(runCount), 0);
    chk("R8 reset flags", int'(lockDetect | holdActive), 0);

    // R9: result lands on the edge after the closing edge
    tick(1, 1, 0);
    chk("R9 count one edge after close", int'(runCount), 0);
    tick(0, 0, 0);
    chk("R9 count two edges after close", int'(runCount), 1);
    doReset();

    // R1 R2: window 4, threshold 3
    windowSize = 4; lockThresh = 3; exitThresh = 4; holdEnable = 0;
    doPair(1, 2, 3);
    doPair(1, 2, 3);
    chk("R1 count after two", int'(runCount), 2);
    chk("R2 not yet locked", int'(lockDetect), 0);
    doPair(1, 2, 3);
    chk("R2 locked at threshold", int'(lockDetect), 1);
    chk("R2 state locked", int'(loopState), 1);
    // R5: error equal to window
    doPair(1, 4, 3);
    chk("R5 miss clears count", int'(runCount), 0);
    chk("R5 miss drops lock", int'(lockDetect), 0);
    // R1 boundary: window-1 counts, feedback leading (R6)
    doPair(1, 3, 3);
    doPair(0, 3, 3);
    chk("R6 fb-first counts", int'(runCount), 2);
    doPair(0, 1, 3);
    chk("R1 window-1 locks", int'(lockDetect), 1);
    // R6 orphan reference
    tick(1, 0, 0); idle(2); tick(1, 0, 0); idle(3);
    chk("R6 orphan clears", int'(runCount), 0);
    chk("R6 orphan unlocks", int'(lockDetect), 0);
    idle(TIMEOUT + 4);
    // R6 timeout
    doPair(1, 1, 3); doPair(1, 1, 3); doPair(1, 1, 3);
    chk("R2 relocked", int'(lockDetect), 1);
    tick(1, 0, 0); idle(TIMEOUT + 4);
    chk("R6 timeout clears", int'(runCount), 0);
    chk("R6 timeout unlocks", int'(lockDetect), 0);
    // R4: switch ignored then taken
    doPair(1, 1, 3); doPair(1, 1, 3); doPair(1, 1, 3);
    tick(0, 0, 1); idle(2);
    chk("R4 disabled switch keeps state", int'(loopState), 1);
    chk("R4 disabled switch keeps count", int'(runCount), 3);
    holdEnable = 1;
    tick(0, 0, 1); idle(2);
    chk("R4 switch enters holdover", int'(holdActive), 1);
    chk("R4 switch clears count", int'(runCount), 0);
    tick(0, 0, 1); idle(2);
    chk("R4 switch in holdover ignored", int'(holdActive), 1);
    // R3: exit count 4
    doPair(1, 1, 3); doPair(1, 1, 3); doPair(1, 1, 3);
    chk("R3 still in holdover", int'(holdActive), 1);
    doPair(1, 6, 3);
    chk("R3 miss in holdover clears", int'(runCount), 0);
    chk("R3 miss keeps holdover", int'(holdActive), 1);
    doPair(1, 1, 3); doPair(1, 1, 3); doPair(1, 1, 3); doPair(1, 1, 3);
    chk("R3 exits to acquire", int'(loopState), 0);
    chk("R3 count kept", int'(runCount), 4);
    doPair(1, 1, 3);
    chk("R2 lock after exit", int'(lockDetect), 1);
    holdEnable = 0;

    // R7 saturation
    doReset();
    lockThresh = 8'd255;
    for (int i = 0; i < 270; i++) doPair(1, 0, 1);
    chk("R7 saturates", int'(runCount), CMAX);
    chk("R7 locked at max", int'(lockDetect), 1);

    // Random phase
    doReset();
    for (int i = 0; i < 400; i++) begin
      int kind;
      windowSize = 8'($urandom_range(1, 8));
      lockThresh = 8'($urandom_range(1, 6));
      exitThresh = 8'($urandom_range(1, 6));
      holdEnable = 1'($urandom_range(0, 1));
      kind = $urandom_range(0, 9);
      if (kind == 0) begin
        tick(1, 0, 0); idle($urandom_range(0, 3)); tick(1, 0, 0); idle(2);
      end else if (kind == 1) begin
        tick(0, 0, 1); idle(1);
      end else if (kind == 2) begin
        tick(1, 1, 1); idle(2);
      end else begin
        doPair(1'($urandom_range(0, 1)), $urandom_range(0, 10), $urandom_range(0, 4));
      end
    end
    idle(TIMEOUT + 4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule